// File: doc/BRIEF.md
# Multicast Copy-Request Cell Splitter

This block is the front stage of an N-input copy network, with N a power of two. In every time slot each input may present a request for a given number of copies of its cell. The block adds the requests up in input order on top of an offset carried over from the previous slot. Each prefix sum is read as two fields. The upper field is the number of slots the copies must wait. The lower field is a position on a ring of N output addresses. From neighbouring sums the block tells whether a request fits in one slot, straddles a slot boundary or fell off the end of the delay field.

For each input the block emits two registered internal headers, a head part and a residual part. Each carries an active flag, a copy count, a delay, a cyclic address interval and an index reference. A per-input loss flag is also registered. A buffering stage and a replicating network downstream consume these headers. A `slot_go` strobe marks the clock cycles that are slot boundaries. On all other cycles the block holds its state.

Top module: `copy_split`

## Requirements
- R1: While reset is asserted every output is zero. The carried offset restarts at zero, so the first slot after reset assigns addresses from 0 with delay 0.
- R2: The prefix sum S_i is DT_W+log2N bits wide and wraps modulo its width. The delay field of a header is the upper DT_W bits of the relevant sum, and addresses are the lower log2N bits. Input 0's predecessor is the carried offset.
- R3: When the delay fields of S_(i-1) and S_i are equal, only the head header is active. It has count c, delay DT_(i-1), min = RS_(i-1), max = (RS_i - 1) mod N and index reference = min. The residual header is inactive.
- R4: When DT_i > DT_(i-1), the request is split. The head header gets count N - RS_(i-1), delay DT_(i-1), min RS_(i-1), max N-1 and index reference RS_(i-1). The residual header gets the remaining count, delay DT_i, min 0, max RS_i - 1, and index reference equal to its min plus the head count, mod N.
- R5: A split whose remaining count is zero (the request exactly fills the slot) leaves the residual header inactive with all fields zero.
- R6: When DT_i < DT_(i-1) (the sum wrapped), the loss flag of input i is set and both of its headers are inactive with all fields zero. Its count still enters the prefix sum.
- R7: An input whose valid flag is low, or whose count is zero, adds nothing to the sum. Both of its headers are inactive with all fields zero, and its loss flag is clear.
- R8: A count above N is treated as exactly N, both in the sum and in the headers.
- R9: The offset carried to the next slot is the final sum S_(N-1), reduced by N when its delay field is nonzero (one slot has elapsed). Otherwise it is carried unchanged.
- R10: Headers and loss flags appear one clock after the slot's inputs are sampled with `slot_go` high. With `slot_go` low, the outputs and the carried offset keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_go | input | 1 | Slot boundary strobe; state advances only when high |
| in_vld | input | N | Per-input request valid |
| in_cnt | input | N*(log2N+1) | Per-input requested copy count, input i at bits i*(log2N+1) upward |
| h0_act | output | N | Head header active |
| h0_cnt | output | N*(log2N+1) | Head header copy count |
| h0_dt | output | N*DT_W | Head header delay in slots |
| h0_min | output | N*log2N | Head header first address |
| h0_max | output | N*log2N | Head header last address |
| h0_idx | output | N*log2N | Head header index reference |
| h1_act | output | N | Residual header active |
| h1_cnt | output | N*(log2N+1) | Residual header copy count |
| h1_dt | output | N*DT_W | Residual header delay in slots |
| h1_min | output | N*log2N | Residual header first address |
| h1_max | output | N*log2N | Residual header last address |
| h1_idx | output | N*log2N | Residual header index reference |
| lost | output | N | Request dropped because the sum wrapped |

## Verification
A split and a wrap loss can occur in the same slot. A wrapped sum restarts low in the delay field, so a later input can then straddle a boundary again. A directed slot with every input requesting N copies on top of a carried backlog provokes exactly that. Heavy random slots repeat it. Every lane of every slot is compared, field by field, against a bench model that recomputes the prefix sums and the carried offset on its own.

// File: rtl/copy_split_pkg.sv
package copy_split_pkg;

  // Classification of one input lane within a slot
  typedef enum logic [1:0] {
    LANE_IDLE  = 2'd0,
    LANE_WHOLE = 2'd1,
    LANE_SPLIT = 2'd2,
    LANE_LOST  = 2'd3
  } lane_kind_e;

endpackage

// File: rtl/copy_split_prefix.sv
module copy_split_prefix #(
  parameter int N     = 8,
  parameter int CNT_W = 4,
  parameter int SUM_W = 6
) (
  input  logic [SUM_W-1:0]   base,
  input  logic [N-1:0]       vld,
  input  logic [N*CNT_W-1:0] cnt,
  output logic [N*SUM_W-1:0] sum_o,
  output logic [N*CNT_W-1:0] eff_o
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(N);

  logic [SUM_W-1:0] s [N];
  logic [CNT_W-1:0] e [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [CNT_W-1:0] raw;
    assign raw = cnt[i*CNT_W +: CNT_W];
    // invalid inputs add nothing; oversized requests clamp to N
    assign e[i] = !vld[i] ? '0 : ((raw > CAP) ? CAP : raw);
    if (i == 0) begin : g_first
      assign s[i] = base + SUM_W'(e[i]);
    end else begin : g_rest
      assign s[i] = s[i-1] + SUM_W'(e[i]);
    end
    assign sum_o[i*SUM_W +: SUM_W] = s[i];
    assign eff_o[i*CNT_W +: CNT_W] = e[i];
  end

endmodule

// File: rtl/copy_split_lane.sv
module copy_split_lane
  import copy_split_pkg::*;
#(
  parameter int N     = 8,
  parameter int DT_W  = 3,
  parameter int LG    = 3,
  parameter int CNT_W = 4,
  parameter int SUM_W = 6
) (
  input  logic [CNT_W-1:0] eff,
  input  logic [SUM_W-1:0] s_prev,
  input  logic [SUM_W-1:0] s_cur,
  output logic             a0,
  output logic [CNT_W-1:0] c0,
  output logic [DT_W-1:0]  d0,
  output logic [LG-1:0]    lo0,
  output logic [LG-1:0]    hi0,
  output logic [LG-1:0]    ix0,
  output logic             a1,
  output logic [CNT_W-1:0] c1,
  output logic [DT_W-1:0]  d1,
  output logic [LG-1:0]    lo1,
  output logic [LG-1:0]    hi1,
  output logic [LG-1:0]    ix1,
  output logic             lost
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(N);

  logic [DT_W-1:0]  dtp, dtc;
  logic [LG-1:0]    rsp, rsc, rsc_m1;
  logic [CNT_W-1:0] head, rest;
  lane_kind_e       kind;

  assign dtp    = s_prev[SUM_W-1:LG];
  assign dtc    = s_cur[SUM_W-1:LG];
  assign rsp    = s_prev[LG-1:0];
  assign rsc    = s_cur[LG-1:0];
  assign rsc_m1 = rsc - LG'(1);
  assign head   = FULL - CNT_W'(rsp);
  assign rest   = eff - head;

  always_comb begin
    if (eff == '0)       kind = LANE_IDLE;
    else if (dtc == dtp) kind = LANE_WHOLE;
    else if (dtc > dtp)  kind = LANE_SPLIT;
    else                 kind = LANE_LOST;
  end

  always_comb begin
    a0 = 1'b0; c0 = '0; d0 = '0; lo0 = '0; hi0 = '0; ix0 = '0;
    a1 = 1'b0; c1 = '0; d1 = '0; lo1 = '0; hi1 = '0; ix1 = '0;
    lost = 1'b0;
    unique case (kind)
      LANE_WHOLE: begin
        a0 = 1'b1; c0 = eff; d0 = dtp;
        lo0 = rsp; hi0 = rsc_m1; ix0 = rsp;
      end
      LANE_SPLIT: begin
        a0 = 1'b1; c0 = head; d0 = dtp;
        lo0 = rsp; hi0 = '1; ix0 = rsp;
        if (rest != '0) begin
          a1 = 1'b1; c1 = rest; d1 = dtc;
          lo1 = '0; hi1 = rsc_m1; ix1 = head[LG-1:0];
        end
      end
      LANE_LOST: lost = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/copy_split.sv
module copy_split #(
  parameter  int N     = 8,
  parameter  int DT_W  = $clog2(N),
  localparam int LG    = $clog2(N),
  localparam int CNT_W = LG + 1,
  localparam int SUM_W = LG + DT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_go,
  input  logic [N-1:0]       in_vld,
  input  logic [N*CNT_W-1:0] in_cnt,
  output logic [N-1:0]       h0_act,
  output logic [N*CNT_W-1:0] h0_cnt,
  output logic [N*DT_W-1:0]  h0_dt,
  output logic [N*LG-1:0]    h0_min,
  output logic [N*LG-1:0]    h0_max,
  output logic [N*LG-1:0]    h0_idx,
  output logic [N-1:0]       h1_act,
  output logic [N*CNT_W-1:0] h1_cnt,
  output logic [N*DT_W-1:0]  h1_dt,
  output logic [N*LG-1:0]    h1_min,
  output logic [N*LG-1:0]    h1_max,
  output logic [N*LG-1:0]    h1_idx,
  output logic [N-1:0]       lost
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // carried offset and prefix sums
  logic [SUM_W-1:0]   fb_q, fb_d;
  logic [N*SUM_W-1:0] sums;
  logic [N*CNT_W-1:0] effs;

  copy_split_prefix #(.N(N), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_prefix (
    .base  (fb_q),
    .vld   (in_vld),
    .cnt   (in_cnt),
    .sum_o (sums),
    .eff_o (effs)
  );

  logic [SUM_W-1:0] s_last;
  assign s_last = sums[(N-1)*SUM_W +: SUM_W];

  always_comb begin
    if (s_last[SUM_W-1:LG] != '0) fb_d = s_last - SUM_W'(N);
    else                          fb_d = s_last;
  end

  // per-lane header generation
  logic [N-1:0]       n0_act, n1_act, n_lost;
  logic [N*CNT_W-1:0] n0_cnt, n1_cnt;
  logic [N*DT_W-1:0]  n0_dt, n1_dt;
  logic [N*LG-1:0]    n0_min, n0_max, n0_idx, n1_min, n1_max, n1_idx;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [SUM_W-1:0] prev;
    if (i == 0) begin : g_first
      assign prev = fb_q;
    end else begin : g_rest
      assign prev = sums[(i-1)*SUM_W +: SUM_W];
    end

    copy_split_lane #(
      .N(N), .DT_W(DT_W), .LG(LG), .CNT_W(CNT_W), .SUM_W(SUM_W)
    ) u_lane (
      .eff    (effs[i*CNT_W +: CNT_W]),
      .s_prev (prev),
      .s_cur  (sums[i*SUM_W +: SUM_W]),
      .a0     (n0_act[i]),
      .c0     (n0_cnt[i*CNT_W +: CNT_W]),
      .d0     (n0_dt[i*DT_W +: DT_W]),
      .lo0    (n0_min[i*LG +: LG]),
      .hi0    (n0_max[i*LG +: LG]),
      .ix0    (n0_idx[i*LG +: LG]),
      .a1     (n1_act[i]),
      .c1     (n1_cnt[i*CNT_W +: CNT_W]),
      .d1     (n1_dt[i*DT_W +: DT_W]),
      .lo1    (n1_min[i*LG +: LG]),
      .hi1    (n1_max[i*LG +: LG]),
      .ix1    (n1_idx[i*LG +: LG]),
      .lost   (n_lost[i])
    );
  end

  // state registers, enabled on slot boundaries
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fb_q   <= '0;
      h0_act <= '0; h0_cnt <= '0; h0_dt <= '0;
      h0_min <= '0; h0_max <= '0; h0_idx <= '0;
      h1_act <= '0; h1_cnt <= '0; h1_dt <= '0;
      h1_min <= '0; h1_max <= '0; h1_idx <= '0;
      lost   <= '0;
    end else if (slot_go) begin
      fb_q   <= fb_d;
      h0_act <= n0_act; h0_cnt <= n0_cnt; h0_dt <= n0_dt;
      h0_min <= n0_min; h0_max <= n0_max; h0_idx <= n0_idx;
      h1_act <= n1_act; h1_cnt <= n1_cnt; h1_dt <= n1_dt;
      h1_min <= n1_min; h1_max <= n1_max; h1_idx <= n1_idx;
      lost   <= n_lost;
    end
  end

endmodule

// File: rtl/copy_split_chk.sv
module copy_split_chk #(
  parameter int N     = 8,
  parameter int DT_W  = 3,
  parameter int LG    = 3,
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               slot_go,
  input logic [N-1:0]       h0_act,
  input logic [N-1:0]       h1_act,
  input logic [N*CNT_W-1:0] h0_cnt,
  input logic [N*CNT_W-1:0] h1_cnt,
  input logic [N*LG-1:0]    h0_max,
  input logic [N*LG-1:0]    h1_min,
  input logic [N-1:0]       lost
);

  // R1: outputs are cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (h0_act == '0 && h1_act == '0 && lost == '0);
    end
  end

  // R10: no slot strobe, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_go |=> $stable(h0_act) && $stable(h1_act) && $stable(lost)
                 && $stable(h0_cnt) && $stable(h1_cnt));

  for (genvar i = 0; i < N; i++) begin : g_lane
    // R4: a residual never appears without its head part
    assert_resid_has_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
      h1_act[i] |-> h0_act[i]);

    // R4: a split ends the head at the last address and restarts the residual at 0
    assert_split_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
      h1_act[i] |-> (h0_max[i*LG +: LG] == '1) && (h1_min[i*LG +: LG] == '0));

    // R6: a dropped request emits no header
    assert_lost_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lost[i] |-> !h0_act[i] && !h1_act[i]);

    // R8: the two parts together never exceed N copies
    assert_cnt_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (h0_cnt[i*CNT_W +: CNT_W] + h1_cnt[i*CNT_W +: CNT_W]) <= (CNT_W+1)'(N));
  end

endmodule

bind copy_split copy_split_chk #(
  .N(N), .DT_W(DT_W), .LG(LG), .CNT_W(CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .slot_go (slot_go),
  .h0_act  (h0_act),
  .h1_act  (h1_act),
  .h0_cnt  (h0_cnt),
  .h1_cnt  (h1_cnt),
  .h0_max  (h0_max),
  .h1_min  (h1_min),
  .lost    (lost)
);

// File: tb/sim_copy_split.sv
module sim_copy_split;

  localparam int N  = 8;
  localparam int DW = 3;
  localparam int LG = 3;
  localparam int CW = 4;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slot_go;
  logic [N-1:0]  in_vld;
  logic [N*CW-1:0] in_cnt;
  logic [N-1:0]  h0_act, h1_act, lost;
  logic [N*CW-1:0] h0_cnt, h1_cnt;
  logic [N*DW-1:0] h0_dt, h1_dt;
  logic [N*LG-1:0] h0_min, h0_max, h0_idx, h1_min, h1_max, h1_idx;

  always #2.5 clk = ~clk;

  copy_split #(.N(N), .DT_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go),
    .in_vld(in_vld), .in_cnt(in_cnt),
    .h0_act(h0_act), .h0_cnt(h0_cnt), .h0_dt(h0_dt),
    .h0_min(h0_min), .h0_max(h0_max), .h0_idx(h0_idx),
    .h1_act(h1_act), .h1_cnt(h1_cnt), .h1_dt(h1_dt),
    .h1_min(h1_min), .h1_max(h1_max), .h1_idx(h1_idx),
    .lost(lost)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model state
  logic [SW-1:0] mfb;
  logic [16:0]   x0 [N];
  logic [16:0]   x1 [N];
  logic          xl [N];
  string         tg [N];

  function automatic logic [16:0] got0(int i);
    return {h0_act[i], h0_cnt[i*CW +: CW], h0_dt[i*DW +: DW],
            h0_min[i*LG +: LG], h0_max[i*LG +: LG], h0_idx[i*LG +: LG]};
  endfunction

  function automatic logic [16:0] got1(int i);
    return {h1_act[i], h1_cnt[i*CW +: CW], h1_dt[i*DW +: DW],
            h1_min[i*LG +: LG], h1_max[i*LG +: LG], h1_idx[i*LG +: LG]};
  endfunction

  task automatic check(string tag, string what, logic [16:0] act, logic [16:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Recompute expected headers for one slot; returns next carried offset
  function automatic logic [SW-1:0] model(logic [N-1:0] v, logic [N*CW-1:0] c);
    logic [SW-1:0] s, p;
    s = mfb;
    for (int i = 0; i < N; i++) begin
      int raw, e, c0, c1;
      logic [DW-1:0] dtp, dtc;
      logic [LG-1:0] rsp, rsc;
      raw = int'(c[i*CW +: CW]);
      e = !v[i] ? 0 : ((raw > N) ? N : raw);
      p = s;
      s = p + SW'(e);
      dtp = p[SW-1:LG]; dtc = s[SW-1:LG];
      rsp = p[LG-1:0];  rsc = s[LG-1:0];
      x0[i] = '0; x1[i] = '0; xl[i] = 1'b0;
      if (e == 0) tg[i] = "R7";
      else if (dtc == dtp) begin
        x0[i] = {1'b1, CW'(e), dtp, rsp, LG'(rsc - 3'd1), rsp};
        tg[i] = (i == 0 && mfb[SW-1:LG] != 0) ? "R9" :
                (i == 0 && mfb != 0) ? "R2" : "R3";
      end else if (dtc > dtp) begin
        c0 = N - int'(rsp);
        c1 = e - c0;
        x0[i] = {1'b1, CW'(c0), dtp, rsp, 3'd7, rsp};
        if (c1 != 0) begin
          x1[i] = {1'b1, CW'(c1), dtc, 3'd0, LG'(rsc - 3'd1), LG'(c0)};
          tg[i] = "R4";
        end else tg[i] = "R5";
      end else begin
        xl[i] = 1'b1;
        tg[i] = "R6";
      end
      if (v[i] && raw > N) tg[i] = "R8";
    end
    return (s[SW-1:LG] != 0) ? s - SW'(N) : s;
  endfunction

  task automatic run_slot(logic go, logic [N-1:0] v, logic [N*CW-1:0] c);
    logic [SW-1:0] nf;
    @(negedge clk);
    slot_go = go; in_vld = v; in_cnt = c;
    if (go) nf = model(v, c);
    else begin
      nf = mfb;
      for (int i = 0; i < N; i++) tg[i] = "R10";
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      check(tg[i], $sformatf("lane %0d head", i), got0(i), x0[i]);
      check(tg[i], $sformatf("lane %0d resid", i), got1(i), x1[i]);
      check(tg[i], $sformatf("lane %0d lost", i), 17'(lost[i]), 17'(xl[i]));
    end
    mfb = nf;
  endtask

  function automatic logic [N*CW-1:0] fill(int k);
    logic [N*CW-1:0] r;
    for (int i = 0; i < N; i++) r[i*CW +: CW] = CW'(k);
    return r;
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; slot_go = 1'b0; in_vld = '0; in_cnt = '0;
    mfb = '0;
    for (int i = 0; i < N; i++) begin x0[i] = '0; x1[i] = '0; xl[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int i = 0; i < N; i++) begin
      check("R1", $sformatf("lane %0d head in reset", i), got0(i), '0);
      check("R1", $sformatf("lane %0d resid in reset", i), got1(i), '0);
    end
    check("R1", "lost in reset", 17'(lost), '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    run_slot(1'b1, '1, fill(1));          // whole lanes, last one fills exactly (R3, R5)
    run_slot(1'b1, '1, fill(3));          // splits with backlog (R4)
    run_slot(1'b1, '1, fill(8));          // wrap loss and split in one slot (R6)
    run_slot(1'b1, 8'hA5, fill(15));      // oversized counts saturate (R8)
    run_slot(1'b1, '0, fill(5));          // nothing valid (R7)
    run_slot(1'b1, '1, fill(0));          // zero counts (R7)
    run_slot(1'b0, '1, fill(6));          // held slot (R10)
    run_slot(1'b1, 8'h0F, fill(2));       // offset survived the hold (R9)
    run_slot(1'b1, 8'h81, fill(8));

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] v;
      logic [N*CW-1:0] c;
      logic go;
      v = N'($urandom);
      for (int i = 0; i < N; i++) begin
        int r;
        r = $urandom_range(0, 19);
        c[i*CW +: CW] = (r == 0) ? CW'(0) : (r == 1) ? CW'(12) : CW'($urandom_range(1, N));
      end
      go = ($urandom_range(0, 19) != 0);
      run_slot(go, v, c);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule